// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This controller sits next to a processor core and decides when the core must leave its program to run a handler. It collects a set of level-sensitive device request lines. It gives each line an enable bit and a programmable urgency value. It then compares the eligible lines against the running priority level and raises a single request towards the core. The request comes with the address of the handler slot. Each cause owns one four-byte slot in a jump table, so the slot address is a base plus four times the cause number. Device lines use causes 0 to NSRC-1. Synchronous causes from the core, such as faults and trap instructions, use the causes that follow.

The block also owns the processor context that entry and exit must change. This context is the single user/supervisor bit, the global interrupt enable, the running priority level, and a one-deep save area holding the interrupted PC, mode, level and enable. On entry the core is moved to supervisor mode and interrupts are switched off. For a device cause, the level is raised to the urgency of the source being served, so only a strictly more urgent source can preempt that handler. A return strobe puts the saved mode, level and enable back, and the core resumes at the saved PC shown on `epc`. The configuration port writes enable bits, urgency values, the level and the global enable. This port is honoured only in supervisor mode.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the live context is supervisor mode, global enable 0, level 0 and `epc` 0, with every source masked and every urgency 0. The save area holds user mode, level 0, enable 1 and PC 0.
- R2: Source i is eligible when `irq_lines[i]` is 1, its enable bit is 1, and its urgency is strictly greater than `cur_level`. `irq_pending` is 1 exactly when the global enable is 1 and at least one source is eligible.
- R3: Among eligible sources, the one with the largest urgency is chosen, and equal urgencies go to the lower index. While `irq_pending` is 1 and `sync_valid` is 0, `vec_addr` equals VEC_BASE + 4 × chosen index.
- R4: In supervisor mode, a write with `cfg_we`=1 takes effect on the next cycle, selected by `cfg_kind`. Kind 0 loads the enable bits from `cfg_wdata`, where bit i set to 1 enables source i. Kind 1 loads the urgency of source `cfg_idx` from `cfg_wdata[PRIO_W-1:0]`. Kind 2 loads the level from `cfg_wdata[PRIO_W-1:0]`. Kind 3 loads the global enable from `cfg_wdata[0]`.
- R5: In user mode, configuration writes are ignored. Enable bits, urgencies, level and global enable all keep their values.
- R6: When `enter`=1, `sync_valid`=0 and `irq_pending`=1, the next cycle shows the following. `epc` holds the `core_pc` of the entry cycle, the mode is supervisor, and the global enable is 0. The level equals the urgency of the chosen source. The previous mode, level and enable are saved.
- R7: While `sync_valid`=1, `vec_addr` equals VEC_BASE + 4 × (NSRC + `sync_cause`). An `enter` with `sync_valid`=1 is accepted whatever the global enable. It saves and switches context as in R6, but it leaves the level unchanged.
- R8: An `enter` with `sync_valid`=0 while `irq_pending`=0 is ignored, so `epc`, mode, level and enable all keep their values.
- R9: When `rte`=1 is not accompanied by an accepted entry, the next cycle restores the saved mode, level and global enable. If an accepted entry and `rte` occur in the same cycle, the entry takes effect and `rte` is dropped.
- R10: Inside a handler whose level is L, a source with urgency at most L never raises `irq_pending`. A source with urgency above L does raise it, and it can be entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | NSRC | Level-sensitive device requests, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 enables, 1 urgency, 2 level, 3 global enable |
| cfg_idx | input | IDX_W | Source selected by an urgency write |
| cfg_wdata | input | NSRC | Write data |
| sync_valid | input | 1 | Core reports a synchronous cause |
| sync_cause | input | SYNC_W | Number of that synchronous cause |
| enter | input | 1 | Core takes the offered entry this cycle |
| rte | input | 1 | Core executes a return from exception |
| core_pc | input | XLEN | PC to save on entry |
| irq_pending | output | 1 | Device interrupt offered to the core |
| vec_addr | output | XLEN | Handler slot address for the offered cause |
| epc | output | XLEN | Saved PC, the return target |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |
| cur_level | output | PRIO_W | Running priority level |
| gie_out | output | 1 | Global interrupt enable |

## Verification
A wrong enable bit, urgency or level shows up on `irq_pending` and `vec_addr` in the same cycle as the request pattern that exposes it. For that reason the bench runs a table of request patterns that covers ties, masked lines and sources at zero urgency. A context fault, such as a lost save, a level that is not raised, or a write that slips through in user mode, only becomes visible one cycle after the entry, write or return strobe. The bench therefore reads `epc`, `cur_level`, `sup_mode` and `gie_out` at the first falling edge after each strobe. It then follows nested entry and return to find faults that surface only on the way back.

// File: rtl/pic_pkg.sv
// Package: shared encodings for the priority-masked interrupt controller.
// Assumes: nothing; holds only enums used across the controller.
package pic_pkg;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } pic_mode_e;

    typedef enum logic [1:0] {
        CFG_MASK  = 2'd0,
        CFG_PRIO  = 2'd1,
        CFG_LEVEL = 2'd2,
        CFG_GIE   = 2'd3
    } pic_cfg_kind_e;

endpackage

// File: rtl/pic_cfg_regs.sv
// Module: source enable bits and per-source urgency registers.
// Assumes: wr_en is already qualified by supervisor mode in the parent.
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               kind,
    input  logic [IDX_W-1:0]         idx,
    input  logic [NSRC-1:0]          wdata,
    output logic [NSRC-1:0]          mask,
    output logic [NSRC*PRIO_W-1:0]   prio_flat
);

    // Enable bits: all sources masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_en && kind == CFG_MASK)
            mask <= wdata;
    end

    // One urgency register per source, addressed by idx.
    for (genvar g = 0; g < NSRC; g++) begin : g_prio
        logic [PRIO_W-1:0] prio_q;

        // Urgency of source g: zero out of reset, loaded on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q <= '0;
            else if (wr_en && kind == CFG_PRIO && idx == IDX_W'(g))
                prio_q <= wdata[PRIO_W-1:0];
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
    end

endmodule

// File: rtl/pic_arbiter.sv
// Module: eligibility filter and urgency arbiter over all sources.
// Assumes: request lines are already synchronous; ties go to the lower index.
module pic_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC-1:0]        mask,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]      level,
    output logic                   any,
    output logic [IDX_W-1:0]       win_idx,
    output logic [PRIO_W-1:0]      win_prio
);

    logic [NSRC-1:0] elig;

    // Source is eligible when requesting, enabled and above the running level.
    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign elig[g] = req[g] && mask[g] && (prio_flat[g*PRIO_W +: PRIO_W] > level);
    end

    // Linear scan: a later source replaces the winner only if strictly more urgent.
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/pic_context.sv
// Module: live processor context (mode, enable, level, saved PC) and its save area.
// Assumes: take_irq and take_sync are mutually exclusive; entry outranks return.
module pic_context
    import pic_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int XLEN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_irq,
    input  logic              take_sync,
    input  logic              do_rte,
    input  logic [XLEN-1:0]   core_pc,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic              lvl_we,
    input  logic [PRIO_W-1:0] lvl_wdata,
    input  logic              gie_we,
    input  logic              gie_wdata,
    output pic_mode_e         mode,
    output logic              gie,
    output logic [PRIO_W-1:0] level,
    output logic [XLEN-1:0]   epc
);

    pic_mode_e         sv_mode;
    logic [PRIO_W-1:0] sv_level;
    logic              sv_gie;
    logic              take;

    assign take = take_irq || take_sync;

    // Save area: captures the interrupted context on every accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc      <= '0;
            sv_mode  <= MODE_USER;
            sv_level <= '0;
            sv_gie   <= 1'b1;
        end else if (take) begin
            epc      <= core_pc;
            sv_mode  <= mode;
            sv_level <= level;
            sv_gie   <= gie;
        end
    end

    // Mode bit: supervisor on entry, saved mode on return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_SUPER;
        else if (take)
            mode <= MODE_SUPER;
        else if (do_rte)
            mode <= sv_mode;
    end

    // Global enable: cleared on entry, restored on return, else written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie <= 1'b0;
        else if (take)
            gie <= 1'b0;
        else if (do_rte)
            gie <= sv_gie;
        else if (gie_we)
            gie <= gie_wdata;
    end

    // Running level: raised to the served urgency, restored on return, else written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= '0;
        else if (take_irq)
            level <= win_prio;
        else if (take_sync)
            level <= level;
        else if (do_rte)
            level <= sv_level;
        else if (lvl_we)
            level <= lvl_wdata;
    end

endmodule

// File: rtl/pic_vector.sv
// Module: selects the offered cause and forms its jump-table slot address.
// Assumes: synchronous causes outrank device causes; slots are four bytes.
module pic_vector #(
    parameter int                NSRC     = 8,
    parameter int                NSYNC    = 4,
    parameter int                IDX_W    = 3,
    parameter int                SYNC_W   = 2,
    parameter int                XLEN     = 32,
    parameter logic [XLEN-1:0]   VEC_BASE = 32'h0000_0100
) (
    input  logic              sync_valid,
    input  logic [SYNC_W-1:0] sync_cause,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [XLEN-1:0]   vec_addr
);

    localparam int CAUSE_W = $clog2(NSRC + NSYNC);

    logic [CAUSE_W-1:0] cause;

    // Cause number: synchronous causes follow the device block.
    always_comb begin
        if (sync_valid)
            cause = CAUSE_W'(NSRC) + CAUSE_W'(sync_cause);
        else
            cause = CAUSE_W'(win_idx);
    end

    assign vec_addr = VEC_BASE + (XLEN'(cause) << 2);

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the priority-masked interrupt controller.
// Assumes: irq_lines synchronous to clk; the core raises enter only on a cycle
// where it takes the offered cause, and rte when it returns to epc.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int              NSRC     = 8,
    parameter int              NSYNC    = 4,
    parameter int              PRIO_W   = 3,
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0100,
    parameter int              IDX_W    = $clog2(NSRC),
    parameter int              SYNC_W   = $clog2(NSYNC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_lines,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [NSRC-1:0]   cfg_wdata,
    input  logic              sync_valid,
    input  logic [SYNC_W-1:0] sync_cause,
    input  logic              enter,
    input  logic              rte,
    input  logic [XLEN-1:0]   core_pc,
    output logic              irq_pending,
    output logic [XLEN-1:0]   vec_addr,
    output logic [XLEN-1:0]   epc,
    output logic              sup_mode,
    output logic [PRIO_W-1:0] cur_level,
    output logic              gie_out
);

    logic [NSRC-1:0]        mask;
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic                   any_elig;
    logic [IDX_W-1:0]       win_idx;
    logic [PRIO_W-1:0]      win_prio;
    pic_mode_e              mode;
    logic                   gie;
    logic                   wr_ok;
    logic                   take_irq;
    logic                   take_sync;
    logic                   do_rte;

    // Writes pass only in supervisor mode.
    assign wr_ok       = cfg_we && (mode == MODE_SUPER);
    assign irq_pending = gie && any_elig;
    assign take_sync   = enter && sync_valid;
    assign take_irq    = enter && !sync_valid && irq_pending;
    assign do_rte      = rte && !(take_irq || take_sync);
    assign sup_mode    = (mode == MODE_SUPER);
    assign gie_out     = gie;

    pic_cfg_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .kind      (cfg_kind),
        .idx       (cfg_idx),
        .wdata     (cfg_wdata),
        .mask      (mask),
        .prio_flat (prio_flat)
    );

    pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .req       (irq_lines),
        .mask      (mask),
        .prio_flat (prio_flat),
        .level     (cur_level),
        .any       (any_elig),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    pic_context #(.PRIO_W(PRIO_W), .XLEN(XLEN)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_irq  (take_irq),
        .take_sync (take_sync),
        .do_rte    (do_rte),
        .core_pc   (core_pc),
        .win_prio  (win_prio),
        .lvl_we    (wr_ok && cfg_kind == CFG_LEVEL),
        .lvl_wdata (cfg_wdata[PRIO_W-1:0]),
        .gie_we    (wr_ok && cfg_kind == CFG_GIE),
        .gie_wdata (cfg_wdata[0]),
        .mode      (mode),
        .gie       (gie),
        .level     (cur_level),
        .epc       (epc)
    );

    pic_vector #(
        .NSRC(NSRC), .NSYNC(NSYNC), .IDX_W(IDX_W), .SYNC_W(SYNC_W),
        .XLEN(XLEN), .VEC_BASE(VEC_BASE)
    ) u_vec (
        .sync_valid (sync_valid),
        .sync_cause (sync_cause),
        .win_idx    (win_idx),
        .vec_addr   (vec_addr)
    );

endmodule

// File: rtl/pic_checker.sv
// Module: temporal checks on the controller's ports, bound into every instance.
// Assumes: the bound instance uses the same PRIO_W and XLEN.
module pic_checker #(
    parameter int PRIO_W = 3,
    parameter int XLEN   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter,
    input logic              sync_valid,
    input logic              rte,
    input logic              cfg_we,
    input logic [XLEN-1:0]   core_pc,
    input logic              irq_pending,
    input logic              sup_mode,
    input logic [PRIO_W-1:0] cur_level,
    input logic              gie_out,
    input logic [XLEN-1:0]   epc
);

    a_r2_pending_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> gie_out);

    a_r6_entry_context: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !sync_valid && irq_pending) |=> (sup_mode && !gie_out && epc == $past(core_pc)));

    a_r6_level_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !sync_valid && irq_pending) |=> (cur_level > $past(cur_level)));

    a_r7_sync_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && sync_valid) |=> (sup_mode && cur_level == $past(cur_level)));

    a_r5_user_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !sup_mode && !enter && !rte) |=> ($stable(cur_level) && $stable(gie_out)));

    a_r8_idle_enter_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !sync_valid && !irq_pending && !rte) |=> ($stable(epc) && $stable(sup_mode)));

endmodule

bind prio_irq_ctrl pic_checker #(.PRIO_W(PRIO_W), .XLEN(XLEN)) u_pic_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter       (enter),
    .sync_valid  (sync_valid),
    .rte         (rte),
    .cfg_we      (cfg_we),
    .core_pc     (core_pc),
    .irq_pending (irq_pending),
    .sup_mode    (sup_mode),
    .cur_level   (cur_level),
    .gie_out     (gie_out),
    .epc         (epc)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: table-driven arbitration walk, then directed context sequences.
module tb_prio_irq_ctrl;

    localparam int NSRC = 8;
    localparam int PRIO_W = 3;
    localparam int XLEN = 32;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  irq_lines = '0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_kind = '0;
    logic [2:0]       cfg_idx = '0;
    logic [NSRC-1:0]  cfg_wdata = '0;
    logic             sync_valid = 1'b0;
    logic [1:0]       sync_cause = '0;
    logic             enter = 1'b0;
    logic             rte = 1'b0;
    logic [XLEN-1:0]  core_pc = '0;
    logic             irq_pending;
    logic [XLEN-1:0]  vec_addr;
    logic [XLEN-1:0]  epc;
    logic             sup_mode;
    logic [PRIO_W-1:0] cur_level;
    logic             gie_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
        .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .sync_valid(sync_valid), .sync_cause(sync_cause), .enter(enter),
        .rte(rte), .core_pc(core_pc), .irq_pending(irq_pending),
        .vec_addr(vec_addr), .epc(epc), .sup_mode(sup_mode),
        .cur_level(cur_level), .gie_out(gie_out)
    );

    // Urgencies: src0=1 src1=3 src2=3 src3=7 src4=2 src5=5 src6=0 src7=4; src5 masked.
    // Entry: {irq_lines[7:0], expected pending, expected cause[2:0]}.
    localparam logic [11:0] TBL [8] = '{
        {8'b0000_0000, 1'b0, 3'd0},   // nothing requested
        {8'b0000_0001, 1'b1, 3'd0},   // single low source
        {8'b0000_0110, 1'b1, 3'd1},   // tie at 3 -> lower index
        {8'b0010_0001, 1'b1, 3'd0},   // src5 masked
        {8'b0100_0000, 1'b0, 3'd0},   // urgency 0 never above level 0
        {8'b1001_0000, 1'b1, 3'd7},   // 4 beats 2
        {8'b1111_1111, 1'b1, 3'd3},   // all: urgency 7 wins
        {8'b0010_0000, 1'b0, 3'd0}    // only the masked source
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] kind, input logic [2:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_enter(input logic [31:0] pc, input logic with_rte);
        @(negedge clk);
        enter = 1'b1; rte = with_rte; core_pc = pc;
        @(negedge clk);
        enter = 1'b0; rte = 1'b0;
    endtask

    task automatic do_rte();
        @(negedge clk);
        rte = 1'b1;
        @(negedge clk);
        rte = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        irq_lines = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 sup_mode", 32'(sup_mode), 32'd1);
        check("R1 gie", 32'(gie_out), 32'd0);
        check("R1 level", 32'(cur_level), 32'd0);
        check("R1 epc", epc, 32'd0);
        check("R1 pending", 32'(irq_pending), 32'd0);

        // R4 configuration in supervisor mode
        cfg_write(2'd0, 3'd0, 8'hDF);
        cfg_write(2'd1, 3'd0, 8'd1);
        cfg_write(2'd1, 3'd1, 8'd3);
        cfg_write(2'd1, 3'd2, 8'd3);
        cfg_write(2'd1, 3'd3, 8'd7);
        cfg_write(2'd1, 3'd4, 8'd2);
        cfg_write(2'd1, 3'd5, 8'd5);
        cfg_write(2'd1, 3'd6, 8'd0);
        cfg_write(2'd1, 3'd7, 8'd4);
        cfg_write(2'd2, 3'd0, 8'd2);
        check("R4 level write", 32'(cur_level), 32'd2);
        cfg_write(2'd2, 3'd0, 8'd0);
        check("R4 level write back", 32'(cur_level), 32'd0);
        cfg_write(2'd3, 3'd0, 8'd1);
        check("R4 gie write", 32'(gie_out), 32'd1);

        // R2 / R3 table walk
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            irq_lines = TBL[k][11:4];
            #1;
            check("R2 pending", 32'(irq_pending), 32'(TBL[k][3]));
            if (TBL[k][3])
                check("R3 vector", vec_addr, BASE + 32'(TBL[k][2:0]) * 4);
        end
        irq_lines = '0;

        // R9 return from reset context -> user, level 0, enable 1
        do_rte();
        check("R9 rte mode", 32'(sup_mode), 32'd0);
        check("R9 rte gie", 32'(gie_out), 32'd1);
        check("R9 rte level", 32'(cur_level), 32'd0);

        // R5 user writes refused
        cfg_write(2'd2, 3'd0, 8'd5);
        check("R5 level kept", 32'(cur_level), 32'd0);
        cfg_write(2'd3, 3'd0, 8'd0);
        check("R5 gie kept", 32'(gie_out), 32'd1);
        cfg_write(2'd0, 3'd0, 8'h00);
        cfg_write(2'd1, 3'd0, 8'd0);
        irq_lines = 8'h01;
        #1;
        check("R5 mask and urgency kept", 32'(irq_pending), 32'd1);

        // R6 interrupt entry on src1 (urgency 3)
        @(negedge clk);
        irq_lines = 8'h02;
        do_enter(32'h40, 1'b0);
        check("R6 mode", 32'(sup_mode), 32'd1);
        check("R6 gie", 32'(gie_out), 32'd0);
        check("R6 level", 32'(cur_level), 32'd3);
        check("R6 epc", epc, 32'h40);
        check("R6 pending off", 32'(irq_pending), 32'd0);

        // R10 preemption rules inside the handler
        cfg_write(2'd3, 3'd0, 8'd1);
        check("R10 same level blocked", 32'(irq_pending), 32'd0);
        irq_lines = 8'h12;
        #1;
        check("R10 lower blocked", 32'(irq_pending), 32'd0);
        irq_lines = 8'h1A;
        #1;
        check("R10 higher offered", 32'(irq_pending), 32'd1);
        check("R10 vector", vec_addr, BASE + 32'd12);
        do_enter(32'h80, 1'b0);
        check("R10 nested level", 32'(cur_level), 32'd7);
        check("R10 nested epc", epc, 32'h80);

        // R9 return from nested entry
        do_rte();
        check("R9 nested level", 32'(cur_level), 32'd3);
        check("R9 nested mode", 32'(sup_mode), 32'd1);
        check("R9 nested gie", 32'(gie_out), 32'd1);

        // R8 idle enter ignored
        irq_lines = '0;
        cfg_write(2'd3, 3'd0, 8'd0);
        do_enter(32'h99, 1'b0);
        check("R8 epc kept", epc, 32'h80);
        check("R8 level kept", 32'(cur_level), 32'd3);

        // R7 synchronous cause
        @(negedge clk);
        sync_valid = 1'b1; sync_cause = 2'd2;
        #1;
        check("R7 sync vector", vec_addr, BASE + 32'd40);
        do_enter(32'hC0, 1'b0);
        sync_valid = 1'b0;
        check("R7 sync epc", epc, 32'hC0);
        check("R7 sync level", 32'(cur_level), 32'd3);
        check("R7 sync mode", 32'(sup_mode), 32'd1);

        // R9 entry outranks a simultaneous return
        @(negedge clk);
        sync_valid = 1'b1; sync_cause = 2'd0;
        do_enter(32'hD0, 1'b1);
        sync_valid = 1'b0;
        check("R9 entry wins epc", epc, 32'hD0);
        check("R9 entry wins gie", 32'(gie_out), 32'd0);

        finish_run();
    end

endmodule